// File: doc/BRIEF.md
# Change-of-State Input Port

This block is a 48-line digital input port on a byte-wide register bus with eight addresses. Each input line is treated as asynchronous and passes through a two-stage synchronizer. The synchronized lines are grouped into six bytes, and the host can read each byte at its own address. Every group also has a change detector, which notices any toggle of any of its eight lines in either direction.

The host turns on change reporting one group at a time through a shared control/status address. When an enabled group changes, the block sets that group's pending bit and raises `irq_o`. The host reads the control/status address to learn which groups changed, and that same read acknowledges the interrupt and clears the pending bits. A change that arrives in the cycle of the acknowledging read is kept for the next read, so no change is lost.

An interrupt state machine drives `irq_o` and has two states. ST_QUIET means nothing is pending. ST_PENDING means at least one group bit is latched. The transition RAISE (ST_QUIET to ST_PENDING) is taken when the next status has any bit set. The transition SETTLE (ST_PENDING to ST_QUIET) is taken when an acknowledge, a cleared enable, or both leave the next status empty. In every other case the machine stays in its current state.

Top module: `cos_input_port`

## Requirements
- R1: Group g holds inputs 8g to 8g+7, with the lowest input in data bit 0. Reads return the synchronized group bytes at these addresses: group 0 at 0, group 1 at 1, group 2 at 2, group 3 at 4, group 4 at 5 and group 5 at 6.
- R2: A read of address 3 returns 0x00.
- R3: A write to address 7 loads the group enable mask from write data bits 5:0. Bit n of the mask enables group n.
- R4: A rising or a falling transition on any line of an enabled group sets that group's pending bit. The bit is visible no more than four clock cycles after the line changes.
- R5: Changes in a group whose enable bit is clear never set its pending bit and never raise `irq_o`.
- R6: A read of address 7 returns the pending group bits in bits 5:0. Bit 6 is 0 when an interrupt is pending and 1 when none is. Bit 7 is always 0.
- R7: A read of address 7 clears every pending bit and drops `irq_o` on the following edge, unless a new change arrives in that same cycle.
- R8: An enabled-group change that is detected in the same cycle as an acknowledging read stays pending after the read.
- R9: Clearing a group's enable bit also clears its pending bit. Writing 0 to address 7 leaves no interrupt pending.
- R10: After reset the enable mask and the pending bits are zero, and `irq_o` is low.
- R11: `irq_o` is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the address is held |
| pins_i | input | 48 | Asynchronous input lines |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is a change that is detected in exactly the same cycle as the acknowledging read of address 7. To produce it, the stimulus first leaves one group pending. It then toggles a second enabled group and starts the status read two edges later, which is when the synchronized byte differs from its previous value. The read must still report the first group. The next read must then report only the second group, which shows that the acknowledge did not swallow it.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int GRP_W     = 8;
    localparam int NUM_GRP   = 6;
    localparam logic [2:0] CTRL_ADDR = 3'd7;

    typedef enum logic {
        ST_QUIET,
        ST_PENDING
    } irq_state_e;

    // Groups 0..2 sit at addresses 0..2, groups 3..5 skip address 3.
    function automatic logic [2:0] grp_addr(input int unsigned g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/cos_change_detect.sv
module cos_change_detect #(
    parameter int GROUPS = 6,
    parameter int GW     = 8,
    localparam int W     = GROUPS * GW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      sync_i,
    output logic [GROUPS-1:0] chg_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign chg_o[g] = |(sync_i[g*GW +: GW] ^ prev_q[g*GW +: GW]);
    end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int GROUPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] chg_i,
    input  logic              en_wr_i,
    input  logic [GROUPS-1:0] en_wdata_i,
    input  logic              ack_i,
    output logic [GROUPS-1:0] en_o,
    output logic [GROUPS-1:0] status_o,
    output logic              irq_o
);
    irq_state_e        state_q, state_d;
    logic [GROUPS-1:0] en_q, en_d;
    logic [GROUPS-1:0] stat_q, stat_d;

    always_comb begin
        en_d   = en_wr_i ? en_wdata_i : en_q;
        stat_d = ((ack_i ? '0 : stat_q) | chg_i) & en_d;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (|stat_d)  state_d = ST_PENDING; // RAISE
            ST_PENDING: if (!(|stat_d)) state_d = ST_QUIET; // SETTLE
            default:    state_d = ST_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            en_q    <= '0;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
            stat_q  <= stat_d;
        end
    end

    // output process
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            ST_QUIET:   irq_o = 1'b0;
            ST_PENDING: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    assign en_o     = en_q;
    assign status_o = stat_q;

    assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|stat_q));

    assert_write_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && en_wdata_i == '0) |=> (stat_q == '0 && !irq_o));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !en_wr_i && !(|(chg_i & en_q))) |=> (stat_q == '0));

    assert_coincident_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !en_wr_i && |(chg_i & en_q)) |=> (|stat_q && irq_o));

    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr_i && stat_q == '0 && !(|(chg_i & en_q))) |=> !irq_o);
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_pkg::*;
#(
    parameter int GROUPS = NUM_GRP,
    parameter int GW     = GRP_W,
    localparam int W     = GROUPS * GW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   bus_addr,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic [W-1:0] pins_i,
    output logic         irq_o
);
    logic [W-1:0]      sync_w;
    logic [GROUPS-1:0] chg_w;
    logic [GROUPS-1:0] en_w;
    logic [GROUPS-1:0] stat_w;
    logic              ctrl_sel;

    assign ctrl_sel = (bus_addr == CTRL_ADDR);

    cos_sync #(.W(W)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_i),
        .sync_o (sync_w)
    );

    cos_change_detect #(.GROUPS(GROUPS), .GW(GW)) det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(sync_w),
        .chg_o (chg_w)
    );

    cos_irq_ctrl #(.GROUPS(GROUPS)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (chg_w),
        .en_wr_i   (bus_wr && ctrl_sel),
        .en_wdata_i(bus_wdata[GROUPS-1:0]),
        .ack_i     (bus_rd && ctrl_sel),
        .en_o      (en_w),
        .status_o  (stat_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctrl_sel) begin
            bus_rdata[GROUPS-1:0] = stat_w;
            bus_rdata[GROUPS]     = ~irq_o;
        end else begin
            for (int g = 0; g < GROUPS; g++) begin
                if (bus_addr == grp_addr(g)) bus_rdata = sync_w[g*GW +: GW];
            end
        end
    end

    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd3) |-> (bus_rdata == 8'h00));

    assert_ctrl_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ctrl_sel) |-> (!bus_rdata[7] && bus_rdata[6] == !irq_o));

    assert_enable_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_w & ~en_w) == '0));
endmodule

// File: tb/cos_input_port_tb_top.sv
module cos_input_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pins = '0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #5 clk = ~clk;

    cos_input_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pins_i   (pins),
        .irq_o    (irq)
    );

    // monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: addr %0d read 0x%02h expected 0x%02h", r, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string r);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); req_q.push_back(r);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq_o %0b expected %0b", r, irq, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk_irq(1'b0, "R10");
        bus_read(3'd7, 8'h40, "R10");

        // R1 group bytes at their addresses, R2 gap
        @(posedge clk); #1 pins = 48'hA5_3C_96_0F_E1_7E;
        settle();
        bus_read(3'd0, 8'h7E, "R1");
        bus_read(3'd1, 8'hE1, "R1");
        bus_read(3'd2, 8'h0F, "R1");
        bus_read(3'd4, 8'h96, "R1");
        bus_read(3'd5, 8'h3C, "R1");
        bus_read(3'd6, 8'hA5, "R1");
        bus_read(3'd3, 8'h00, "R2");
        bus_read(3'd7, 8'h40, "R5");

        // R3 R4 rising edge in enabled group 1
        bus_write(3'd7, 8'h02);
        pins[15:8] = 8'hFF;
        settle();
        chk_irq(1'b1, "R4");
        bus_read(3'd7, 8'h02, "R6");
        chk_irq(1'b0, "R7");
        bus_read(3'd7, 8'h40, "R7");

        // R4 falling edge
        pins[15:8] = 8'h00;
        settle();
        chk_irq(1'b1, "R11");
        bus_read(3'd7, 8'h02, "R4");

        // R5 disabled group 0 toggles
        pins[7:0] = ~pins[7:0];
        settle();
        chk_irq(1'b0, "R5");
        bus_read(3'd7, 8'h40, "R5");

        // R3 multiple groups enabled
        bus_write(3'd7, 8'h24);
        pins[16] = ~pins[16];
        pins[47] = ~pins[47];
        settle();
        bus_read(3'd7, 8'h24, "R3");
        bus_read(3'd7, 8'h40, "R7");

        // R9 clearing enable drops pending
        bus_write(3'd7, 8'h04);
        pins[20] = ~pins[20];
        settle();
        chk_irq(1'b1, "R9");
        bus_write(3'd7, 8'h00);
        chk_irq(1'b0, "R9");
        bus_read(3'd7, 8'h40, "R9");

        // R8 change coincident with acknowledge
        bus_write(3'd7, 8'h03);
        pins[0] = ~pins[0];
        settle();
        @(posedge clk); #1 pins[8] = ~pins[8];
        @(posedge clk);
        bus_read(3'd7, 8'h01, "R8");
        chk_irq(1'b1, "R8");
        bus_read(3'd7, 8'h02, "R8");
        bus_read(3'd7, 8'h40, "R8");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule